// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a 20-bit physical memory address for a 16-bit processor datapath. For ordinary data accesses it builds the 16-bit effective offset from any mix of an optional base register (BX or BP), an optional index register (SI or DI) and an optional 16-bit displacement. It then picks the segment register implied by those operands: SS when BP takes part, DS otherwise. A segment-override request from the decoder may replace that choice.

Fixed access kinds bypass the mode fields. Instruction fetch pairs CS with IP, and stack access pairs SS with SP. A string read pairs DS (or an overriding segment) with SI, and a string write always pairs ES with DI. The physical address is the segment value shifted left by four bits plus the offset, truncated to 20 bits. It is produced combinationally. A registered copy is also captured on a request strobe for paths that need a flop boundary.

Top module: `seg_agen`

## Requirements
- R1: `phys_addr` equals (segment value × 16 + `eff_off`) modulo 100000h, where the segment value is the input named by `seg_code`.
- R2: For a data access, `eff_off` is the modulo-10000h sum of the base term, the index term and the displacement term. The base term is `bx` when `base_sel`=1, `bp` when `base_sel`=2, and 0 when `base_sel` is 0 or 3. The index term is `si` when `idx_sel`=1, `di` when `idx_sel`=2, and 0 when `idx_sel` is 0 or 3. The displacement term is `disp` when `use_disp`=1 and 0 otherwise.
- R3: For a data access without override, `seg_code` is SS (2) when `base_sel`=2 and DS (3) otherwise. The segment codes are ES=0, CS=1, SS=2, DS=3.
- R4: For a data access with `ovr_en`=1, `seg_code` equals `ovr_seg`.
- R5: An instruction fetch gives `seg_code`=CS and `eff_off`=`ip`. The override and mode fields have no effect on it.
- R6: A stack access gives `seg_code`=SS and `eff_off`=`sp`. The override and mode fields have no effect on it.
- R7: A string read gives `eff_off`=`si` and `seg_code`=DS, or `ovr_seg` when `ovr_en`=1.
- R8: A string write gives `seg_code`=ES and `eff_off`=`di`. An override has no effect on it.
- R9: The `access` encoding is 0 data, 1 fetch, 2 stack, 3 string read and 4 string write. The codes 5 to 7 behave as a data access.
- R10: After reset, `phys_q` and `phys_vld_q` are 0. After a clock edge where `req`=1, `phys_vld_q`=1 and `phys_q` holds the `phys_addr` of that cycle. After an edge where `req`=0, `phys_vld_q`=0 and `phys_q` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Capture strobe for the registered address |
| access | input | 3 | Access kind |
| base_sel | input | 2 | Base register select |
| idx_sel | input | 2 | Index register select |
| use_disp | input | 1 | Add displacement |
| disp | input | 16 | Displacement |
| ovr_en | input | 1 | Segment override request |
| ovr_seg | input | 2 | Override segment code |
| bx | input | 16 | BX value |
| bp | input | 16 | BP value |
| si | input | 16 | SI value |
| di | input | 16 | DI value |
| sp | input | 16 | SP value |
| ip | input | 16 | IP value |
| cs | input | 16 | CS value |
| ds | input | 16 | DS value |
| ss | input | 16 | SS value |
| es | input | 16 | ES value |
| eff_off | output | 16 | Effective offset |
| seg_code | output | 2 | Chosen segment code |
| phys_addr | output | 20 | Combinational physical address |
| phys_q | output | 20 | Registered physical address |
| phys_vld_q | output | 1 | Registered address valid |

## Verification
The assertions assume that every input is a known 0/1 value at each rising edge, and that `access`, `ovr_en` and `ovr_seg` hold a single decoded value for the whole cycle. The override checks also rely on the decoder raising `ovr_en` only together with a legal 2-bit code, which any 2-bit value satisfies. The stimulus changes inputs only just after a falling edge and draws every field from its full range, including the spare access codes 5 to 7 and the unused select value 3. This keeps the bench inside those assumptions while reaching every branch.

// File: rtl/seg_agen_pkg.sv
package seg_agen_pkg;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_code_e;

    typedef enum logic [2:0] {
        ACC_DATA  = 3'd0,
        ACC_FETCH = 3'd1,
        ACC_STACK = 3'd2,
        ACC_SRC   = 3'd3,
        ACC_DST   = 3'd4
    } acc_e;

    localparam logic [1:0] BASE_BX = 2'd1;
    localparam logic [1:0] BASE_BP = 2'd2;
    localparam logic [1:0] IDX_SI  = 2'd1;
    localparam logic [1:0] IDX_DI  = 2'd2;

endpackage

// File: rtl/seg_agen_offset.sv
module seg_agen_offset
    import seg_agen_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic [2:0]       access,
    input  logic [1:0]       base_sel,
    input  logic [1:0]       idx_sel,
    input  logic             use_disp,
    input  logic [OFF_W-1:0] disp,
    input  logic [OFF_W-1:0] bx,
    input  logic [OFF_W-1:0] bp,
    input  logic [OFF_W-1:0] si,
    input  logic [OFF_W-1:0] di,
    input  logic [OFF_W-1:0] sp,
    input  logic [OFF_W-1:0] ip,
    output logic [OFF_W-1:0] off,
    output logic             uses_bp
);

    logic [OFF_W-1:0] base_term;
    logic [OFF_W-1:0] idx_term;
    logic [OFF_W-1:0] disp_term;

    always_comb begin
        base_term = '0;
        uses_bp   = 1'b0;
        if (base_sel == BASE_BX) begin
            base_term = bx;
        end else if (base_sel == BASE_BP) begin
            base_term = bp;
            uses_bp   = 1'b1;
        end

        idx_term = '0;
        if (idx_sel == IDX_SI) begin
            idx_term = si;
        end else if (idx_sel == IDX_DI) begin
            idx_term = di;
        end

        disp_term = use_disp ? disp : '0;

        case (access)
            ACC_FETCH: off = ip;
            ACC_STACK: off = sp;
            ACC_SRC:   off = si;
            ACC_DST:   off = di;
            default:   off = base_term + idx_term + disp_term;
        endcase
    end

endmodule

// File: rtl/seg_agen_segsel.sv
module seg_agen_segsel
    import seg_agen_pkg::*;
(
    input  logic [2:0] access,
    input  logic       uses_bp,
    input  logic       ovr_en,
    input  logic [1:0] ovr_seg,
    output logic [1:0] seg_code
);

    seg_code_e sel;

    always_comb begin
        case (access)
            ACC_FETCH: sel = SEG_CS;
            ACC_STACK: sel = SEG_SS;
            ACC_DST:   sel = SEG_ES;
            ACC_SRC:   sel = ovr_en ? seg_code_e'(ovr_seg) : SEG_DS;
            default: begin
                if (ovr_en) begin
                    sel = seg_code_e'(ovr_seg);
                end else if (uses_bp) begin
                    sel = SEG_SS;
                end else begin
                    sel = SEG_DS;
                end
            end
        endcase
        seg_code = sel;
    end

endmodule

// File: rtl/seg_agen_sum.sv
module seg_agen_sum
    import seg_agen_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20
) (
    input  logic [1:0]       seg_code,
    input  logic [SEG_W-1:0] cs,
    input  logic [SEG_W-1:0] ds,
    input  logic [SEG_W-1:0] ss,
    input  logic [SEG_W-1:0] es,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  phys
);

    localparam int WIDE_W = SEG_W + SHIFT;

    logic [SEG_W-1:0]  seg_val;
    logic [WIDE_W-1:0] seg_shifted;
    logic [PA_W-1:0]   base_term;
    logic [PA_W-1:0]   off_term;

    always_comb begin
        case (seg_code_e'(seg_code))
            SEG_ES:  seg_val = es;
            SEG_CS:  seg_val = cs;
            SEG_SS:  seg_val = ss;
            default: seg_val = ds;
        endcase
        seg_shifted = {seg_val, {SHIFT{1'b0}}};
        base_term   = PA_W'(seg_shifted);
        off_term    = PA_W'(off);
        phys        = base_term + off_term;
    end

endmodule

// File: rtl/seg_agen.sv
module seg_agen
    import seg_agen_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [2:0]       access,
    input  logic [1:0]       base_sel,
    input  logic [1:0]       idx_sel,
    input  logic             use_disp,
    input  logic [OFF_W-1:0] disp,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_seg,
    input  logic [OFF_W-1:0] bx,
    input  logic [OFF_W-1:0] bp,
    input  logic [OFF_W-1:0] si,
    input  logic [OFF_W-1:0] di,
    input  logic [OFF_W-1:0] sp,
    input  logic [OFF_W-1:0] ip,
    input  logic [SEG_W-1:0] cs,
    input  logic [SEG_W-1:0] ds,
    input  logic [SEG_W-1:0] ss,
    input  logic [SEG_W-1:0] es,
    output logic [OFF_W-1:0] eff_off,
    output logic [1:0]       seg_code,
    output logic [PA_W-1:0]  phys_addr,
    output logic [PA_W-1:0]  phys_q,
    output logic             phys_vld_q
);

    typedef struct packed {
        logic [PA_W-1:0] addr;
        logic            vld;
    } state_t;

    logic   uses_bp;
    state_t st_d, st_q;

    seg_agen_offset #(.OFF_W(OFF_W)) u_off (
        .access   (access),
        .base_sel (base_sel),
        .idx_sel  (idx_sel),
        .use_disp (use_disp),
        .disp     (disp),
        .bx       (bx),
        .bp       (bp),
        .si       (si),
        .di       (di),
        .sp       (sp),
        .ip       (ip),
        .off      (eff_off),
        .uses_bp  (uses_bp)
    );

    seg_agen_segsel u_seg (
        .access   (access),
        .uses_bp  (uses_bp),
        .ovr_en   (ovr_en),
        .ovr_seg  (ovr_seg),
        .seg_code (seg_code)
    );

    seg_agen_sum #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT),
        .PA_W  (PA_W)
    ) u_sum (
        .seg_code (seg_code),
        .cs       (cs),
        .ds       (ds),
        .ss       (ss),
        .es       (es),
        .off      (eff_off),
        .phys     (phys_addr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req;
        if (req) begin
            st_d.addr = phys_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phys_q     = st_q.addr;
    assign phys_vld_q = st_q.vld;

    assert_fetch_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        access == ACC_FETCH |-> (seg_code == SEG_CS && eff_off == ip));

    assert_stack_ss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        access == ACC_STACK |-> (seg_code == SEG_SS && eff_off == sp));

    assert_dst_es_R8: assert property (@(posedge clk) disable iff (!rst_n)
        access == ACC_DST |-> (seg_code == SEG_ES && eff_off == di));

    assert_bp_default_ss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (access == ACC_DATA && !ovr_en && base_sel == BASE_BP) |-> seg_code == SEG_SS);

    assert_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (access == ACC_DATA && ovr_en) |-> seg_code == ovr_seg);

    assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (phys_vld_q && phys_q == $past(phys_addr)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!phys_vld_q && $stable(phys_q)));

endmodule

// File: tb/seg_agen_tb_top.sv
`timescale 1ns/1ps
module seg_agen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  access = '0;
    logic [1:0]  base_sel = '0;
    logic [1:0]  idx_sel = '0;
    logic        use_disp = 1'b0;
    logic [15:0] disp = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic [15:0] bx = '0, bp = '0, si = '0, di = '0, sp = '0, ip = '0;
    logic [15:0] cs = '0, ds = '0, ss = '0, es = '0;
    logic [15:0] eff_off;
    logic [1:0]  seg_code;
    logic [19:0] phys_addr;
    logic [19:0] phys_q;
    logic        phys_vld_q;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q    = 0;
    int exp_vld  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    seg_agen dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .access(access),
        .base_sel(base_sel), .idx_sel(idx_sel), .use_disp(use_disp),
        .disp(disp), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
        .bx(bx), .bp(bp), .si(si), .di(di), .sp(sp), .ip(ip),
        .cs(cs), .ds(ds), .ss(ss), .es(es),
        .eff_off(eff_off), .seg_code(seg_code), .phys_addr(phys_addr),
        .phys_q(phys_q), .phys_vld_q(phys_vld_q)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference of the requirements
    task automatic model(output int off, output int seg, output int pa,
                         output string tag);
        int sv;
        int a = int'(access);
        if (a == 1) begin
            off = ip; seg = 1; tag = "R5";
        end else if (a == 2) begin
            off = sp; seg = 2; tag = "R6";
        end else if (a == 3) begin
            off = si; seg = ovr_en ? int'(ovr_seg) : 3; tag = "R7";
        end else if (a == 4) begin
            off = di; seg = 0; tag = "R8";
        end else begin
            off = 0;
            if (base_sel == 2'd1) off += bx;
            if (base_sel == 2'd2) off += bp;
            if (idx_sel == 2'd1)  off += si;
            if (idx_sel == 2'd2)  off += di;
            if (use_disp)         off += disp;
            off = off % 65536;
            if (ovr_en) seg = ovr_seg;
            else        seg = (base_sel == 2'd2) ? 2 : 3;
            tag = (a > 4) ? "R9" : (ovr_en ? "R4" : "R3");
        end
        case (seg)
            0: sv = es;
            1: sv = cs;
            2: sv = ss;
            default: sv = ds;
        endcase
        pa = (sv * 16 + off) % 32'h100000;
    endtask

    // one cycle: wait for falling edge, compare every output
    task automatic step();
        int off, seg, pa;
        string tag;
        @(negedge clk);
        model(off, seg, pa, tag);
        if (req) begin
            exp_q = pa;
            exp_vld = 1;
        end else begin
            exp_vld = 0;
        end
        check((tag == "R3" || tag == "R4" || tag == "R9") ? "R2" : tag,
              int'(eff_off), off);
        check(tag, int'(seg_code), seg);
        check("R1", int'(phys_addr), pa);
        check("R10", int'(phys_q), exp_q);
        check("R10", int'(phys_vld_q), exp_vld);
    endtask

    task automatic set_data(input logic [1:0] b, input logic [1:0] x,
                            input logic ud, input logic [15:0] d);
        access = 3'd0; base_sel = b; idx_sel = x; use_disp = ud; disp = d;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bx = 16'h0123; bp = 16'h0240; si = 16'h1000; di = 16'h2002;
        sp = 16'hFFFE; ip = 16'h0057;
        cs = 16'h1000; ds = 16'h2100; ss = 16'h4100; es = 16'h3000;
        repeat (3) @(negedge clk);
        check("R10", int'(phys_q), 0);      // reset state R10
        check("R10", int'(phys_vld_q), 0);
        rst_n = 1'b1;

        // R1: 1234:0005 -> 12345
        ds = 16'h1234; set_data(2'd0, 2'd0, 1'b1, 16'h0005); req = 1'b1;
        step();
        check("R1", int'(phys_addr), 32'h12345);
        // R2: base+index+disp, DS
        ds = 16'h2100; set_data(2'd1, 2'd1, 1'b1, 16'h0007);
        step();
        check("R2", int'(phys_addr), 32'h2212A);
        // R3: BP selects SS
        set_data(2'd2, 2'd1, 1'b1, 16'h0002);
        step();
        check("R3", int'(phys_addr), 32'h42242);
        // R2: offset wrap
        bx = 16'hFFFF; si = 16'h0002; set_data(2'd1, 2'd1, 1'b1, 16'h0001);
        step();
        check("R2", int'(eff_off), 16'h0002);
        // R1: physical wrap
        ds = 16'hFFFF; bx = 16'h0020; set_data(2'd1, 2'd0, 1'b0, 16'h0);
        step();
        check("R1", int'(phys_addr), 32'h00010);
        // R4: override ES on BP-based access
        ovr_en = 1'b1; ovr_seg = 2'd0; set_data(2'd2, 2'd0, 1'b0, 16'h0);
        step();
        check("R4", int'(seg_code), 0);
        // R5: fetch ignores override
        access = 3'd1; ovr_seg = 2'd3;
        step();
        check("R5", int'(phys_addr), 32'h10057);
        // R6: stack ignores override
        access = 3'd2;
        step();
        check("R6", int'(seg_code), 2);
        // R7: string read takes override
        access = 3'd3; ovr_seg = 2'd1;
        step();
        check("R7", int'(seg_code), 1);
        // R8: string write ignores override
        access = 3'd4; ovr_seg = 2'd3;
        step();
        check("R8", int'(seg_code), 0);
        // R9: spare code behaves as data
        ovr_en = 1'b0; access = 3'd7; base_sel = 2'd2;
        step();
        check("R9", int'(seg_code), 2);
        // R10: hold without request
        req = 1'b0; access = 3'd1; ip = 16'h1111;
        step();
        step();
        check("R10", int'(phys_vld_q), 0);

        for (int k = 0; k < 2000; k++) begin
            req = 1'($urandom); access = 3'($urandom);
            base_sel = 2'($urandom); idx_sel = 2'($urandom);
            use_disp = 1'($urandom); disp = 16'($urandom);
            ovr_en = 1'($urandom); ovr_seg = 2'($urandom);
            bx = 16'($urandom); bp = 16'($urandom); si = 16'($urandom);
            di = 16'($urandom); sp = 16'($urandom); ip = 16'($urandom);
            cs = 16'($urandom); ds = 16'($urandom); ss = 16'($urandom);
            es = 16'($urandom);
            step();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule